// File: doc/BRIEF.md
# Two-Bank GPIO Controller with Edge-Triggered Interrupts

This block is a general-purpose I/O peripheral whose pins are divided at a configurable boundary into a low ("core") bank and a high ("resume") bank. Both banks have the same register layout. For every pin, each bank holds an enable, a direction, an output level, separate rising- and falling-edge trigger enables, an interrupt mask, a routing bit kept only as storage, and a sticky trigger status. Software reaches all of it through a small synchronous byte-wide register port.

Each pin input passes through a two-flop synchronizer. Edges are found by comparing the synchronized value with its previous sample. An edge whose trigger is enabled latches that pin's status bit. Software clears a status bit by writing 1 to it. A single level interrupt output stays high while any unmasked status bit is set. The pin driver is turned on only for pins that are both enabled and configured as outputs.

Top module: `bgpio_ctrl`

## Requirements
- R1: After reset, every pin is an input with its driver off. The trigger enables, interrupt masks, routing bits and status bits are all 0. The pin enables equal the reset-mask parameter (default 0x077F). The interrupt output is low.
- R2: The core bank is selected when address bit 5 is 0 and the resume bank when it is 1. Pins at or above SPLIT are rebased by subtracting SPLIT. Address bits 4:2 select the register: 0 enable, 1 direction, 2 level, 3 rising trigger, 4 falling trigger, 5 interrupt mask, 6 routing, 7 status. Address bits 1:0 select byte (rebased pin / 8), and the pin sits at bit (rebased pin mod 8). Read data is registered and appears one clock after the address is presented.
- R3: A direction bit of 1 makes the pin an input and 0 makes it an output. pin_oe for a pin is high only when its enable bit is 1 and its direction bit is 0.
- R4: A write to a level bit is ignored while that pin is an input and takes effect while it is an output. pin_out carries the stored level.
- R5: Reading a level bit returns the synchronized pin input for an input pin and the stored level for an output pin.
- R6: Rising and falling trigger enables act independently. With either enable set, the matching edge sets the status bit. With both set, each edge does. With neither set, no edge does. The status bit is set on the third rising clock edge after the input changes.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R8: When an enabled edge and a write-1 clear of the same status bit occur in the same cycle, the bit stays set.
- R9: irq is high exactly while some status bit and its interrupt mask bit are both 1. A mask bit of 0 keeps that pin out of irq.
- R10: Reads return 0 for bits above the last pin of a bank and for byte addresses beyond the bytes a bank needs.
- R11: Routing bits can be written and read back, and they affect no other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 6 | Register byte address |
| reg_wr | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| pin_in | input | NUM_PINS | Pin input levels (asynchronous) |
| pin_oe | output | NUM_PINS | Per-pin driver enable |
| pin_out | output | NUM_PINS | Per-pin driven level |
| irq | output | 1 | Combined level interrupt |

## Verification
Edge capture is exercised in four trigger configurations: rising only, falling only, both, and neither. Each is applied to pins in the core bank and in the resume bank, including a pin in the second core byte. This separates a polarity mix-up from a rebasing or byte-select error. The level register is exercised with pins set as inputs and as outputs, and with disabled and enabled output pins, which tells apart the level-write gate, the read-source mux and the driver-enable condition. A status clear is issued in the same cycle as a fresh edge to check that the event takes priority. Writes of 0 and reads of unmapped bytes confirm that nothing changes.

// File: rtl/bgpio_pkg.sv
package bgpio_pkg;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        SEL_EN   = 3'd0,
        SEL_DIR  = 3'd1,
        SEL_LVL  = 3'd2,
        SEL_RISE = 3'd3,
        SEL_FALL = 3'd4,
        SEL_IEN  = 3'd5,
        SEL_SMI  = 3'd6,
        SEL_STS  = 3'd7
    } reg_sel_e;

endpackage

// File: rtl/bgpio_sync.sv
module bgpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] sync,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = raw;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync = st_q.s2;
    assign rise = st_q.s2 & ~st_q.prev;
    assign fall = ~st_q.s2 & st_q.prev;

endmodule

// File: rtl/bgpio_bank.sv
module bgpio_bank
    import bgpio_pkg::*;
#(
    parameter int           W        = 8,
    parameter logic         BANK_SEL = 1'b0,
    parameter logic [W-1:0] EN_RST   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [W-1:0]      pin_sync,
    input  logic [W-1:0]      pin_rise,
    input  logic [W-1:0]      pin_fall,
    output logic [DATA_W-1:0] rdata,
    output logic [W-1:0]      oe,
    output logic [W-1:0]      out,
    output logic              irq
);

    localparam logic [2:0] NBYTES = 3'((W + 7) / 8);

    typedef struct packed {
        logic [W-1:0] en;
        logic [W-1:0] dir;
        logic [W-1:0] lvl;
        logic [W-1:0] rise;
        logic [W-1:0] fall;
        logic [W-1:0] ien;
        logic [W-1:0] smi;
        logic [W-1:0] sts;
    } bank_t;

    bank_t    bk_d, bk_q;
    logic     hit;
    logic     byte_ok;
    reg_sel_e sel;
    logic [W-1:0] rd_bits;

    assign hit     = (addr[5] == BANK_SEL);
    assign byte_ok = ({1'b0, addr[1:0]} < NBYTES);
    assign sel     = reg_sel_e'(addr[4:2]);

    always_comb begin
        bk_d = bk_q;
        for (int i = 0; i < W; i++) begin
            if (wr && hit && addr[1:0] == 2'(i / 8)) begin
                case (sel)
                    SEL_EN:   bk_d.en[i]   = wdata[3'(i % 8)];
                    SEL_DIR:  bk_d.dir[i]  = wdata[3'(i % 8)];
                    SEL_LVL:  if (!bk_q.dir[i]) bk_d.lvl[i] = wdata[3'(i % 8)];
                    SEL_RISE: bk_d.rise[i] = wdata[3'(i % 8)];
                    SEL_FALL: bk_d.fall[i] = wdata[3'(i % 8)];
                    SEL_IEN:  bk_d.ien[i]  = wdata[3'(i % 8)];
                    SEL_SMI:  bk_d.smi[i]  = wdata[3'(i % 8)];
                    default:  if (wdata[3'(i % 8)]) bk_d.sts[i] = 1'b0;
                endcase
            end
            // a fresh event applied after the clear so it wins
            if ((pin_rise[i] && bk_q.rise[i]) || (pin_fall[i] && bk_q.fall[i]))
                bk_d.sts[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q     <= '0;
            bk_q.en  <= EN_RST;
            bk_q.dir <= '1;
        end else begin
            bk_q <= bk_d;
        end
    end

    always_comb begin
        case (sel)
            SEL_EN:   rd_bits = bk_q.en;
            SEL_DIR:  rd_bits = bk_q.dir;
            SEL_LVL:  rd_bits = (bk_q.dir & pin_sync) | (~bk_q.dir & bk_q.lvl);
            SEL_RISE: rd_bits = bk_q.rise;
            SEL_FALL: rd_bits = bk_q.fall;
            SEL_IEN:  rd_bits = bk_q.ien;
            SEL_SMI:  rd_bits = bk_q.smi;
            default:  rd_bits = bk_q.sts;
        endcase
        rdata = '0;
        if (hit && byte_ok) begin
            for (int i = 0; i < W; i++) begin
                if (addr[1:0] == 2'(i / 8)) rdata[3'(i % 8)] = rd_bits[i];
            end
        end
    end

    assign oe  = bk_q.en & ~bk_q.dir;
    assign out = bk_q.lvl;
    assign irq = |(bk_q.sts & bk_q.ien);

endmodule

// File: rtl/bgpio_ctrl.sv
module bgpio_ctrl
    import bgpio_pkg::*;
#(
    parameter int                  NUM_PINS = 14,
    parameter int                  SPLIT    = 10,
    parameter logic [NUM_PINS-1:0] EN_RST   = 14'h077F
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [5:0]          reg_addr,
    input  logic                reg_wr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_out,
    output logic                irq
);

    localparam int CORE_W = SPLIT;
    localparam int RES_W  = NUM_PINS - SPLIT;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } port_t;

    port_t pt_d, pt_q;

    logic [NUM_PINS-1:0] sync_v, rise_v, fall_v;
    logic [DATA_W-1:0]   core_rd, res_rd;
    logic                core_irq, res_irq;

    bgpio_sync #(.W(NUM_PINS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (pin_in),
        .sync (sync_v),
        .rise (rise_v),
        .fall (fall_v)
    );

    bgpio_bank #(
        .W       (CORE_W),
        .BANK_SEL(1'b0),
        .EN_RST  (EN_RST[CORE_W-1:0])
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (reg_addr),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .pin_sync(sync_v[CORE_W-1:0]),
        .pin_rise(rise_v[CORE_W-1:0]),
        .pin_fall(fall_v[CORE_W-1:0]),
        .rdata   (core_rd),
        .oe      (pin_oe[CORE_W-1:0]),
        .out     (pin_out[CORE_W-1:0]),
        .irq     (core_irq)
    );

    bgpio_bank #(
        .W       (RES_W),
        .BANK_SEL(1'b1),
        .EN_RST  (EN_RST[NUM_PINS-1:CORE_W])
    ) u_resume (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (reg_addr),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .pin_sync(sync_v[NUM_PINS-1:CORE_W]),
        .pin_rise(rise_v[NUM_PINS-1:CORE_W]),
        .pin_fall(fall_v[NUM_PINS-1:CORE_W]),
        .rdata   (res_rd),
        .oe      (pin_oe[NUM_PINS-1:CORE_W]),
        .out     (pin_out[NUM_PINS-1:CORE_W]),
        .irq     (res_irq)
    );

    always_comb begin
        pt_d       = pt_q;
        pt_d.rdata = core_rd | res_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pt_q <= '0;
        else        pt_q <= pt_d;
    end

    assign reg_rdata = pt_q.rdata;
    assign irq       = core_irq | res_irq;

endmodule

// File: rtl/bgpio_ctrl_chk.sv
module bgpio_ctrl_chk #(
    parameter int NUM_PINS = 14,
    parameter int SPLIT    = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic [5:0]          reg_addr,
    input logic                reg_wr,
    input logic [7:0]          reg_rdata,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] pin_out,
    input logic                irq
);

    localparam logic [2:0] CORE_B = 3'((SPLIT + 7) / 8);
    localparam logic [2:0] RES_B  = 3'((NUM_PINS - SPLIT + 7) / 8);

    logic unmapped;
    assign unmapped = reg_addr[5] ? ({1'b0, reg_addr[1:0]} >= RES_B)
                                  : ({1'b0, reg_addr[1:0]} >= CORE_B);

    // R1: while held in reset, drivers off and interrupt low
    a_r1_reset_outputs: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && pin_out == '0 && !irq));

    // R3: driver enables move only after a register write
    a_r3_oe_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(pin_oe));

    // R4: driven levels move only after a register write
    a_r4_out_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(pin_out));

    // R9: interrupt drops only through a clear or a mask write
    a_r9_irq_drops_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(reg_wr));

    // R10: bytes beyond a bank read as zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |=> (reg_rdata == 8'h00));

endmodule

bind bgpio_ctrl bgpio_ctrl_chk #(.NUM_PINS(NUM_PINS), .SPLIT(SPLIT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_rdata(reg_rdata),
    .pin_oe   (pin_oe),
    .pin_out  (pin_out),
    .irq      (irq)
);

// File: tb/bgpio_ctrl_test.sv
module bgpio_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [13:0] pin_in = '0;
    logic [13:0] pin_oe, pin_out;
    logic        irq;

    int checks = 0;
    int errors = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    bgpio_ctrl uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .pin_in   (pin_in),
        .pin_oe   (pin_oe),
        .pin_out  (pin_out),
        .irq      (irq)
    );

    // monitor: compares registered read data one edge after a read is issued
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (reg_rdata !== e) begin
                errors++;
                $display("FAIL %s: rdata actual %h expected %h", t, reg_rdata, e);
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        reg_addr = a;
        reg_wr   = 1'b0;
        @(posedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic chk(input logic [15:0] act, input logic [15:0] e, input string t);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", t, act, e);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic drive_pin(input int p, input logic v);
        @(negedge clk);
        pin_in[p] = v;
        settle();
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk({2'b0, pin_oe}, 16'h0000, "R1 pin_oe");
        chk({15'b0, irq}, 16'h0000, "R1 irq");
        rd(6'h00, 8'h7F, "R1 core enable byte0");
        rd(6'h01, 8'h03, "R1 core enable byte1");
        rd(6'h20, 8'h01, "R1 resume enable");
        rd(6'h04, 8'hFF, "R1 core dir byte0");
        rd(6'h05, 8'h03, "R1 R10 core dir byte1 unused bits");
        rd(6'h24, 8'h0F, "R1 R10 resume dir unused bits");
        rd(6'h1C, 8'h00, "R1 core status");

        // R10 unmapped bytes
        rd(6'h02, 8'h00, "R10 core byte2");
        rd(6'h21, 8'h00, "R10 resume byte1");
        rd(6'h23, 8'h00, "R10 resume byte3");

        // R4 level write ignored while input
        wr(6'h08, 8'hFF);
        @(negedge clk);
        chk({2'b0, pin_out}, 16'h0000, "R4 level ignored on inputs");
        rd(6'h08, 8'h00, "R4 R5 level read inputs");

        // R3 output driver needs enable and dir=0
        wr(6'h04, 8'hF7);
        @(negedge clk);
        chk({2'b0, pin_oe}, 16'h0008, "R3 pin3 output");
        wr(6'h08, 8'hFF);
        @(negedge clk);
        chk({2'b0, pin_out}, 16'h0008, "R4 level applies on output only");
        rd(6'h08, 8'h08, "R5 level read output");

        // R2 R3 resume pin 12 (rebased 2)
        wr(6'h24, 8'h0B);
        @(negedge clk);
        chk({2'b0, pin_oe}, 16'h0008, "R3 disabled output stays off");
        wr(6'h20, 8'h05);
        @(negedge clk);
        chk({2'b0, pin_oe}, 16'h1008, "R2 R3 resume pin12 driven");
        wr(6'h28, 8'h0F);
        @(negedge clk);
        chk({2'b0, pin_out}, 16'h1008, "R2 R4 resume level");
        rd(6'h28, 8'h04, "R2 R5 resume level read");

        // R5 synchronized input read
        drive_pin(1, 1'b1);
        rd(6'h08, 8'h0A, "R5 input pin1 high");

        // R6 R9 rising trigger on pin5
        wr(6'h0C, 8'h20);
        wr(6'h14, 8'h20);
        drive_pin(5, 1'b1);
        chk({15'b0, irq}, 16'h0001, "R9 irq on unmasked status");
        rd(6'h1C, 8'h20, "R6 rising captured");
        wr(6'h1C, 8'h00);
        rd(6'h1C, 8'h20, "R7 zero write keeps status");
        wr(6'h1C, 8'h20);
        @(negedge clk);
        chk({15'b0, irq}, 16'h0000, "R7 R9 clear drops irq");
        drive_pin(5, 1'b0);
        rd(6'h1C, 8'h00, "R6 fall ignored with rising only");

        // R8 event vs clear in the same cycle
        drive_pin(5, 1'b1);
        rd(6'h1C, 8'h20, "R8 setup status");
        drive_pin(5, 1'b0);
        @(negedge clk);
        pin_in[5] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        wr(6'h1C, 8'h20);
        rd(6'h1C, 8'h20, "R8 event wins over clear");
        wr(6'h1C, 8'h20);
        rd(6'h1C, 8'h00, "R8 later clear works");

        // R6 R9 falling only on pin6, masked
        wr(6'h10, 8'h40);
        drive_pin(6, 1'b1);
        rd(6'h1C, 8'h00, "R6 rise ignored with falling only");
        drive_pin(6, 1'b0);
        rd(6'h1C, 8'h40, "R6 falling captured");
        chk({15'b0, irq}, 16'h0000, "R9 masked pin no irq");
        wr(6'h1C, 8'h40);

        // R2 R6 pin 8 in core byte1
        wr(6'h0D, 8'h01);
        drive_pin(8, 1'b1);
        rd(6'h1D, 8'h01, "R2 R6 pin8 byte1 status");
        chk({15'b0, irq}, 16'h0000, "R9 pin8 masked");
        wr(6'h15, 8'h01);
        @(negedge clk);
        chk({15'b0, irq}, 16'h0001, "R9 unmask raises irq");
        wr(6'h1D, 8'h01);
        @(negedge clk);
        chk({15'b0, irq}, 16'h0000, "R7 pin8 clear");

        // R2 R6 both edges on resume pin 11 (rebased 1)
        wr(6'h2C, 8'h02);
        wr(6'h30, 8'h02);
        drive_pin(11, 1'b1);
        rd(6'h3C, 8'h02, "R6 both: rise");
        wr(6'h3C, 8'h02);
        drive_pin(11, 1'b0);
        rd(6'h3C, 8'h02, "R6 both: fall");
        wr(6'h3C, 8'h02);
        rd(6'h3C, 8'h00, "R7 resume clear");

        // R6 neither enable on pin13
        drive_pin(13, 1'b1);
        drive_pin(13, 1'b0);
        rd(6'h3C, 8'h00, "R6 no trigger enables");

        // R11 routing bits are storage only
        wr(6'h18, 8'h5A);
        wr(6'h38, 8'h03);
        rd(6'h18, 8'h5A, "R11 core routing readback");
        rd(6'h38, 8'h03, "R11 resume routing readback");
        @(negedge clk);
        chk({15'b0, irq}, 16'h0000, "R11 no irq effect");
        chk({2'b0, pin_oe}, 16'h1008, "R11 no driver effect");

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule